// File: doc/BRIEF.md
# Tracking Converter Up/Down Controller

This block is the digital half of a tracking analog-to-digital converter. An external DAC turns the block's output word into a voltage, and two external comparators report on which side of a ±1/2 LSB window around that voltage the analog input lies. One comparator says the input is above the window and the other says it is below. The block steps its word one LSB toward the input on each clock. While the error stays inside the window, it holds the word and raises a ready flag.

The output word is also the conversion result. A steady input gives a steady word, so software only needs to read when the value has moved. A sticky flag marks any movement of the word, and a single-cycle read strobe clears it. The comparator inputs are taken as already synchronous to the clock. Reset is synchronous and active high.

Top module: `trk_adc_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, that edge sets `code` to 0, `ready` to 0 and `changed` to 0.
- R2: With `cmp_up`=1 and `cmp_dn`=0 at an edge and `code` below all-ones, that edge raises `code` by exactly 1 and clears `ready`.
- R3: With `cmp_dn`=1 and `cmp_up`=0 at an edge and `code` above zero, that edge lowers `code` by exactly 1 and clears `ready`.
- R4: With both comparator inputs at 0 at an edge, `code` keeps its value and that edge sets `ready` to 1.
- R5: With both comparator inputs at 1 at an edge (illegal state), `code` keeps its value and that edge clears `ready`.
- R6: `code` saturates. A step up at all-ones leaves it at all-ones, and a step down at zero leaves it at zero. It never wraps.
- R7: Between two consecutive clock edges outside reset, `code` changes by at most one LSB.
- R8: Any edge that changes `code` also sets `changed` to 1.
- R9: A high `rd_clr` at an edge where `code` does not change clears `changed`. If `code` changes at that same edge, `changed` ends up at 1.
- R10: Without `rd_clr`, `changed` stays at 1 once set, including through hold and illegal cycles.
- R11: After reset, an input held above the window drives `code` from 0 to all-ones in exactly 2^N-1 clock edges. Ready is then reported one edge after the comparators show the error is inside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_up | input | 1 | Input is above the window; step up |
| cmp_dn | input | 1 | Input is below the window; step down |
| rd_clr | input | 1 | Read strobe that clears the change flag |
| code | output | N | Tracking word, fed to the DAC and used as the result |
| ready | output | 1 | Error was inside the window at the last edge |
| changed | output | 1 | Sticky flag: word has moved since the last read strobe |

## Verification
Every result here is registered once. The word, the ready flag and the change flag all reflect the comparator and strobe levels present at the single rising edge just before they are observed. The bench drives inputs shortly after a rising edge and compares outputs one edge later against an arithmetic model. Each check therefore sits exactly one cycle after its stimulus. A small width is swept over all eight input combinations, at starting words that include both saturation ends. Long tracking runs cover acquisition time and settling.

// File: rtl/trk_pkg.sv
package trk_pkg;

    typedef enum logic [1:0] {
        WIN_HOLD  = 2'b00,
        WIN_RISE  = 2'b01,
        WIN_FALL  = 2'b10,
        WIN_FAULT = 2'b11
    } win_t;

    typedef struct packed {
        win_t win;
        logic clr;
    } ctl_t;

    function automatic win_t classify(input logic above, input logic below);
        case ({below, above})
            2'b00:   return WIN_HOLD;
            2'b01:   return WIN_RISE;
            2'b10:   return WIN_FALL;
            default: return WIN_FAULT;
        endcase
    endfunction

endpackage

// File: rtl/trk_window_decode.sv
module trk_window_decode
    import trk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic above,
    input  logic below,
    input  logic rd_clr,
    output ctl_t ctl,
    output logic ready
);

    always_comb begin
        ctl.win = classify(above, below);
        ctl.clr = rd_clr;
    end

    always_ff @(posedge clk) begin
        if (rst) ready <= 1'b0;
        else     ready <= (ctl.win == WIN_HOLD);
    end

    a_r5_fault_not_ready: assert property (@(posedge clk) disable iff (rst)
        (above && below) |=> !ready);

endmodule

// File: rtl/trk_step_counter.sv
module trk_step_counter
    import trk_pkg::*;
#(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  win_t         win,
    output logic [N-1:0] code,
    output logic         moved
);

    localparam logic [N-1:0] TOP = {N{1'b1}};
    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    logic [N-1:0] code_nx;

    always_comb begin
        code_nx = code;
        if (win == WIN_RISE && code != TOP) code_nx = code + ONE;
        if (win == WIN_FALL && code != '0)  code_nx = code - ONE;
        moved = (code_nx != code);
    end

    always_ff @(posedge clk) begin
        if (rst) code <= '0;
        else     code <= code_nx;
    end

    a_r7_single_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (code == $past(code) || code == $past(code) + ONE
                         || code == $past(code) - ONE));

    a_r6_no_wrap_top: assert property (@(posedge clk) disable iff (rst)
        (code == TOP && win == WIN_RISE) |=> code == TOP);

    a_r6_no_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        (code == '0 && win == WIN_FALL) |=> code == '0);

endmodule

// File: rtl/trk_change_flag.sv
module trk_change_flag #(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         moved,
    input  logic         clr,
    input  logic [N-1:0] code,
    output logic         changed
);

    always_ff @(posedge clk) begin
        if (rst)        changed <= 1'b0;
        else if (moved) changed <= 1'b1;
        else if (clr)   changed <= 1'b0;
    end

    a_r8_flag_on_move: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && code != $past(code)) |-> changed);

    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        (changed && !clr) |=> changed);

endmodule

// File: rtl/trk_adc_ctrl.sv
module trk_adc_ctrl
    import trk_pkg::*;
#(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cmp_up,
    input  logic         cmp_dn,
    input  logic         rd_clr,
    output logic [N-1:0] code,
    output logic         ready,
    output logic         changed
);

    ctl_t ctl;
    logic moved;

    trk_window_decode u_dec (
        .clk(clk), .rst(rst), .above(cmp_up), .below(cmp_dn),
        .rd_clr(rd_clr), .ctl(ctl), .ready(ready)
    );

    trk_step_counter #(.N(N)) u_cnt (
        .clk(clk), .rst(rst), .win(ctl.win), .code(code), .moved(moved)
    );

    trk_change_flag #(.N(N)) u_flg (
        .clk(clk), .rst(rst), .moved(moved), .clr(ctl.clr),
        .code(code), .changed(changed)
    );

    a_r4_hold_inside: assert property (@(posedge clk) disable iff (rst)
        (!cmp_up && !cmp_dn) |=> (ready && $stable(code)));

    a_r5_fault_hold: assert property (@(posedge clk) disable iff (rst)
        (cmp_up && cmp_dn) |=> $stable(code));

    a_r9_clear_quiet: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !cmp_up && !cmp_dn) |=> !changed);

endmodule

// File: tb/test_trk_adc_ctrl.sv
module test_trk_adc_ctrl;

    localparam int N   = 5;
    localparam int MAX = (1 << N) - 1;

    logic clk = 0, rst = 1, cmp_up = 0, cmp_dn = 0, rd_clr = 0;
    logic [N-1:0] code;
    logic ready, changed;

    int checks = 0, errors = 0;
    int mcode = 0, mready = 0, mchg = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    trk_adc_ctrl #(.N(N)) i_trk_adc_ctrl (
        .clk(clk), .rst(rst), .cmp_up(cmp_up), .cmp_dn(cmp_dn),
        .rd_clr(rd_clr), .code(code), .ready(ready), .changed(changed)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // One edge of stimulus, model update, then compare one edge later.
    task automatic step(input bit u, input bit d, input bit s, input string req);
        bit mv = 0;
        cmp_up = u; cmp_dn = d; rd_clr = s;
        if (u && !d && mcode < MAX) begin mcode++; mv = 1; end
        else if (d && !u && mcode > 0) begin mcode--; mv = 1; end
        mready = (!u && !d) ? 1 : 0;
        if (mv) mchg = 1; else if (s) mchg = 0;
        @(posedge clk); #1;
        chk({req, " code"}, int'(code), mcode);
        chk({req, " ready"}, int'(ready), mready);
        chk({req, " changed"}, int'(changed), mchg);
    endtask

    task automatic do_reset();
        rst = 1; cmp_up = 0; cmp_dn = 0; rd_clr = 0;
        @(posedge clk); #1;
        mcode = 0; mready = 0; mchg = 0;
        chk("R1 code", int'(code), 0);
        chk("R1 ready", int'(ready), 0);
        chk("R1 changed", int'(changed), 0);
        rst = 0;
    endtask

    // Track toward a target like an ideal comparator pair would.
    task automatic track_to(input int t, input string req);
        for (int k = 0; k < 2 * MAX && mcode != t; k++)
            step(t > mcode, t < mcode, 0, req);
        step(0, 0, 0, req);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int starts[5];
        starts = '{0, 1, MAX / 2, MAX - 1, MAX};
        @(posedge clk); #1;
        do_reset();

        // R11: acquisition from zero to full scale
        begin
            int n = 0;
            while (mcode < MAX && n < 4 * MAX) begin
                step(1, 0, 0, "R11 acquire");
                n++;
            end
            chk("R11 cycles", n, MAX);
            step(0, 0, 0, "R11 ready");
            chk("R11 ready flag", int'(ready), 1);
        end

        // R6: saturation at both ends
        step(1, 0, 0, "R6 top");
        step(1, 0, 1, "R6 top clr");
        chk("R6 top hold", int'(code), MAX);
        track_to(0, "R3 descend");
        step(0, 1, 0, "R6 zero");
        chk("R6 zero hold", int'(code), 0);

        // Near-exhaustive: every input combination at several start words
        foreach (starts[i]) begin
            for (int c = 0; c < 8; c++) begin
                track_to(starts[i], "R2 R3 settle");
                step(0, 0, c[0], "R9 prep");
                step(c[2], c[1], c[0], "R2 R3 R4 R5 R9 sweep");
                step(0, 0, 0, "R10 sticky");
                step(1, 1, 0, "R5 R10 fault");
            end
        end

        // R8/R9: change and strobe at the same edge
        track_to(10, "R8 settle");
        step(1, 0, 1, "R9 set wins");
        chk("R9 set wins flag", int'(changed), 1);
        step(0, 0, 1, "R9 clear");
        chk("R9 clear flag", int'(changed), 0);

        // Tracking sweep over all targets, up then in a scattered order
        for (int t = 0; t <= MAX; t++) track_to(t, "R7 sweep up");
        for (int t = 0; t <= MAX; t++) track_to((t * 13) % (MAX + 1), "R7 scatter");

        // R1: reset mid-run
        track_to(7, "R1 prep");
        do_reset();

        finish_run();
    end

endmodule